// File: doc/BRIEF.md
# Toeplitz Receive-Side Hash Engine

The engine computes a 32-bit receive-side-scaling hash over a byte string built from selected packet header fields, such as the two IPv4 addresses taken from IP header bytes 12–15 and 16–19. The fields are fed in the order in which they appear in the packet. The hash is a Toeplitz-style product. Walking the input from its left-most bit, every set bit XORs the current top 32 bits of a sliding window over a 320-bit secret key into an accumulator. The window then moves left by one bit, whether the input bit was set or not.

Software loads the key as ten 32-bit words and fills a 128-entry redirection table. The hash input arrives one byte per clock, marked by a valid strobe, a first-byte flag and a last-byte flag. One cycle after the last byte, the block presents the hash, a queue number looked up in the table with the hash's low 7 bits, and a 5-bit queue tag. An upstream parser can mark a packet as unclassifiable. For such a packet the hash, the queue and the tag are all forced to zero, so the packet lands in queue 0.

Top module: `rss_hash_engine`

## Requirements
- R1: Key word w (0 to 9) written through the key port holds key bytes 4w to 4w+3, with byte 4w in bits 31:24. Key byte 0 bit 7 is the first key bit. A one-byte input of 0x80 yields exactly key word 0.
- R2: For each input bit that is 1, taken from byte 0 onward and MSB first within each byte, the 32 key bits starting at that bit's position are XORed into the result. A one-byte input of 0x01 yields key bits 7 to 38.
- R3: The accumulator restarts from zero on every accepted byte flagged first. Inputs of 1 to 36 bytes give the full hash. Cycles with the valid strobe low may fall between the bytes of an input without changing its result.
- R4: When a byte flagged last is accepted, out_valid is high in the following cycle only, and out_hash carries the result at that time.
- R5: out_queue equals redirection table entry hash[6:0]. Entry i is written through the table port, with the write taking effect from the next cycle.
- R6: For a parsed packet, out_tag is {1'b1, out_queue zero-extended to 4 bits}.
- R7: When in_unparsed is high with the last byte, out_hash, out_queue and out_tag are all zero.
- R8: The key is captured when the first byte is accepted. Key writes made later during the same input do not change that input's hash, and they do apply to the next input.
- R9: After reset, out_valid, out_hash, out_queue and out_tag are zero, and the key and the table read as zero.
- R10: in_first and in_last have no effect while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_addr | input | 4 | Key word index, 0 to 9 |
| key_wr_data | input | 32 | Key word value |
| tbl_wr_en | input | 1 | Redirection table write strobe |
| tbl_wr_addr | input | 7 | Table entry index |
| tbl_wr_data | input | 4 | Queue number stored in the entry |
| in_valid | input | 1 | Input byte valid |
| in_first | input | 1 | First byte of a hash input |
| in_last | input | 1 | Last byte of a hash input |
| in_unparsed | input | 1 | Packet could not be classified, sampled with the last byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Result strobe, one cycle |
| out_hash | output | 32 | Hash result |
| out_queue | output | 4 | Queue number from the redirection table |
| out_tag | output | 5 | Queue tag |

## Verification
Single-byte inputs of 0x80 and 0x01 isolate the bit ordering. The first returns the key's first word unchanged, and the second returns the window shifted by seven bits, so a byte-order or bit-order swap shows up at once. Inputs of 36 zero bytes and 36 0xFF bytes exercise the empty XOR and the deepest reach into the key. A 12-byte address-and-port pattern, the same input sent with idle gaps, and inputs sent back to back separate a correct per-packet restart from a state that leaks between or within packets. Unparsed packets, key writes during an input, and stray first/last flags without the valid strobe each check that a side input is honoured or ignored exactly as specified.

// File: rtl/rss_pkg.sv
// Shared constants and the unrolled one-byte hash step for the receive hash engine.
package rss_pkg;
    localparam int KEY_BITS  = 320;
    localparam int KEY_WORDS = KEY_BITS / 32;
    localparam int HASH_W    = 32;
    localparam int MAX_BYTES = (KEY_BITS - HASH_W) / 8;
    localparam int IDX_W     = 7;
    localparam int TAG_W     = 5;

    // Applies eight per-bit steps: bit 7 of the byte first, window top bits first.
    function automatic logic [HASH_W-1:0] mix_byte(input logic [HASH_W-1:0] acc,
                                                   input logic [7:0] b,
                                                   input logic [HASH_W+7:0] win);
        logic [HASH_W-1:0] r;
        r = acc;
        for (int i = 0; i < 8; i++) begin
            if (b[7-i]) r = r ^ win[HASH_W+7-i -: HASH_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/rss_key_store.sv
// Holds the secret key as word registers and presents it as one flat vector.
// Assumes word w carries key bytes 4w..4w+3, byte 4w in the top bits.
module rss_key_store #(
    parameter int WORDS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            wr_addr,
    input  logic [31:0]           wr_data,
    output logic [WORDS*32-1:0]   key_flat
);
    logic [31:0] words [WORDS];

    // Stores a key word on a write to an in-range index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) words[w] <= '0;
        end else if (wr_en && (32'(wr_addr) < WORDS)) begin
            words[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign key_flat[WORDS*32-1-32*g -: 32] = words[g];
    end
endmodule

// File: rtl/rss_hash_core.sv
// Byte-serial Toeplitz accumulator: keeps a shifting key window and a running
// XOR. Assumes at most MAX_BYTES bytes per input so the window stays valid.
module rss_hash_core
    import rss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KEY_BITS-1:0]  key_flat,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic [7:0]           in_data,
    output logic [HASH_W-1:0]    acc_next
);
    logic [KEY_BITS-1:0] window;
    logic [KEY_BITS-1:0] win_src;
    logic [HASH_W-1:0]   acc;
    logic [HASH_W-1:0]   acc_src;

    // Picks a fresh key and zero accumulator on a first byte, else the running state.
    always_comb begin
        win_src  = in_first ? key_flat : window;
        acc_src  = in_first ? '0 : acc;
        acc_next = mix_byte(acc_src, in_data, win_src[KEY_BITS-1 -: HASH_W+8]);
    end

    // Advances the accumulator and shifts the window by one byte per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            window <= '0;
        end else if (in_valid) begin
            acc    <= acc_next;
            window <= win_src << 8;
        end
    end
endmodule

// File: rtl/rss_redirect.sv
// Redirection table: register array written by software, read combinationally.
module rss_redirect #(
    parameter int IDX_W = 7,
    parameter int QW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [QW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [QW-1:0]    rd_data
);
    localparam int ENTRIES = 1 << IDX_W;
    logic [QW-1:0] entries [ENTRIES];

    // Writes one table entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) entries[i] <= '0;
        end else if (wr_en) begin
            entries[wr_addr] <= wr_data;
        end
    end

    assign rd_data = entries[rd_addr];
endmodule

// File: rtl/rss_hash_engine.sv
// Top of the receive hash engine: key store, byte-serial hash core, redirection
// table and a result register. Assumes QW <= TAG_W-1 and inputs of 1..36 bytes.
module rss_hash_engine
    import rss_pkg::*;
#(
    parameter int QW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_en,
    input  logic [3:0]        key_wr_addr,
    input  logic [31:0]       key_wr_data,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_addr,
    input  logic [QW-1:0]     tbl_wr_data,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_unparsed,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic [HASH_W-1:0] out_hash,
    output logic [QW-1:0]     out_queue,
    output logic [TAG_W-1:0]  out_tag
);
    localparam int QEXT = TAG_W - 1;

    logic [KEY_BITS-1:0] key_flat;
    logic [HASH_W-1:0]   acc_next;
    logic [QW-1:0]       tbl_q;
    logic                first_ok;
    logic                finish;

    assign first_ok = in_valid & in_first;
    assign finish   = in_valid & in_last;

    rss_key_store #(.WORDS(KEY_WORDS)) key_i (
        .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_addr(key_wr_addr),
        .wr_data(key_wr_data), .key_flat(key_flat)
    );

    rss_hash_core core_i (
        .clk(clk), .rst_n(rst_n), .key_flat(key_flat), .in_valid(in_valid),
        .in_first(first_ok), .in_data(in_data), .acc_next(acc_next)
    );

    rss_redirect #(.IDX_W(IDX_W), .QW(QW)) table_i (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data), .rd_addr(acc_next[IDX_W-1:0]), .rd_data(tbl_q)
    );

    // Registers the result on the last byte, forcing zeros for unparsed packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hash  <= '0;
            out_queue <= '0;
            out_tag   <= '0;
        end else begin
            out_valid <= finish;
            if (finish) begin
                if (in_unparsed) begin
                    out_hash  <= '0;
                    out_queue <= '0;
                    out_tag   <= '0;
                end else begin
                    out_hash  <= acc_next;
                    out_queue <= tbl_q;
                    out_tag   <= {1'b1, QEXT'(tbl_q)};
                end
            end
        end
    end
endmodule

// File: rtl/rss_hash_checker.sv
// Protocol and output checks for the receive hash engine, bound to the top.
module rss_hash_checker
    import rss_pkg::*;
#(
    parameter int QW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_last,
    input logic              in_unparsed,
    input logic              out_valid,
    input logic [HASH_W-1:0] out_hash,
    input logic [QW-1:0]     out_queue,
    input logic [TAG_W-1:0]  out_tag
);
    int unsigned byte_cnt;

    // Counts bytes of the current input to bound its length.
    always_ff @(posedge clk) begin
        if (!rst_n) byte_cnt <= 0;
        else if (in_valid) byte_cnt <= in_first ? 1 : byte_cnt + 1;
    end

    assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= MAX_BYTES);

    assert_valid_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_valid);

    assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_unparsed)) |->
            (out_tag == {1'b1, (TAG_W-1)'(out_queue)}));

    assert_unparsed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_unparsed)) |->
            (out_hash == '0 && out_queue == '0 && out_tag == '0));
endmodule

bind rss_hash_engine rss_hash_checker #(.QW(QW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_unparsed(in_unparsed), .out_valid(out_valid),
    .out_hash(out_hash), .out_queue(out_queue), .out_tag(out_tag)
);

// File: tb/rss_hash_engine_tb_top.sv
// Bench: behavioural reference compared every clock plus directed checks.
module rss_hash_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr_en = 1'b0;
    logic [3:0]  key_wr_addr = '0;
    logic [31:0] key_wr_data = '0;
    logic        tbl_wr_en = 1'b0;
    logic [6:0]  tbl_wr_addr = '0;
    logic [3:0]  tbl_wr_data = '0;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_unparsed = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [31:0] out_hash;
    logic [3:0]  out_queue;
    logic [4:0]  out_tag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_on = 0;
    string cur_req = "R2";

    always #4 clk = ~clk;

    rss_hash_engine dut_i (.*);

    logic [31:0] key_words [10];
    logic [7:0]  m_key [40];
    logic [7:0]  m_snap [40];
    logic [3:0]  m_tbl [128];
    logic [7:0]  m_bytes [$];
    logic [7:0]  pkt [$];
    bit          exp_v = 0, exp_unp = 0;
    logic [31:0] exp_h = '0;
    logic [3:0]  exp_q = '0;
    logic [4:0]  exp_t = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference hash from the bit-level definition over the snapshotted key.
    function automatic logic [31:0] ref_hash();
        logic [31:0] res = '0;
        for (int i = 0; i < m_bytes.size() * 8; i++) begin
            if (m_bytes[i / 8][7 - (i % 8)]) begin
                for (int j = 0; j < 32; j++) begin
                    int p = i + j;
                    if (p < 320 && m_snap[p / 8][7 - (p % 8)]) res[31 - j] = ~res[31 - j];
                end
            end
        end
        return res;
    endfunction

    // Cycle model: consumes inputs at each edge, then applies writes seen at that edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 0; exp_h = '0; exp_q = '0; exp_t = '0;
            foreach (m_key[i]) m_key[i] = '0;
            foreach (m_tbl[i]) m_tbl[i] = '0;
        end else begin
            exp_v = 0;
            if (in_valid) begin
                if (in_first) begin
                    m_bytes.delete();
                    m_snap = m_key;
                end
                m_bytes.push_back(in_data);
                if (in_last) begin
                    exp_v = 1;
                    exp_unp = in_unparsed;
                    if (in_unparsed) begin
                        exp_h = '0; exp_q = '0; exp_t = '0;
                    end else begin
                        exp_h = ref_hash();
                        exp_q = m_tbl[exp_h[6:0]];
                        exp_t = {1'b1, exp_q};
                    end
                end
            end
            if (key_wr_en && key_wr_addr < 10)
                for (int b = 0; b < 4; b++) m_key[4 * key_wr_addr + b] = key_wr_data[31 - 8 * b -: 8];
            if (tbl_wr_en) m_tbl[tbl_wr_addr] = tbl_wr_data;
        end
    end

    // Compares the design with the model away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            check(out_valid == exp_v, "R4", "out_valid", 32'(out_valid), 32'(exp_v));
            if (exp_v && out_valid) begin
                check(out_hash == exp_h, exp_unp ? "R7" : cur_req, "out_hash", out_hash, exp_h);
                check(out_queue == exp_q, exp_unp ? "R7" : "R5", "out_queue", 32'(out_queue), 32'(exp_q));
                check(out_tag == exp_t, exp_unp ? "R7" : "R6", "out_tag", 32'(out_tag), 32'(exp_t));
            end
        end
    end

    task automatic send(input bit unp, input int gap);
        for (int i = 0; i < pkt.size(); i++) begin
            in_valid = 1; in_first = (i == 0); in_last = (i == pkt.size() - 1);
            in_unparsed = unp; in_data = pkt[i];
            @(posedge clk); #1;
            if (gap > 0 && i != pkt.size() - 1) begin
                in_valid = 0; in_first = 1; in_last = 1;
                repeat (gap) begin @(posedge clk); #1; end
            end
        end
        in_valid = 0; in_first = 0; in_last = 0; in_unparsed = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        key_words = '{32'h6d5a56da, 32'h255b0ec2, 32'h4167253d, 32'h43a38fb0, 32'hd0ca2bcb,
                      32'hae7b30b4, 32'h77cb2da3, 32'h8030f20c, 32'h6a42b73b, 32'hbeac01fa};
        idle(3);
        rst_n = 1; #0;
        @(negedge clk);
        // R9: reset state
        check(out_valid == 0 && out_hash == 0 && out_queue == 0 && out_tag == 0, "R9",
              "reset outputs", out_hash, 0);
        @(posedge clk); #1;
        pkt = '{8'hff};
        send(0, 0);
        @(negedge clk);
        check(out_hash == 0, "R9", "hash with cleared key", out_hash, 0);
        model_on = 1;
        idle(1);
        // R1: load key words; R5: load table
        for (int w = 0; w < 10; w++) begin
            key_wr_en = 1; key_wr_addr = 4'(w); key_wr_data = key_words[w];
            idle(1);
        end
        key_wr_en = 0;
        for (int i = 0; i < 128; i++) begin
            tbl_wr_en = 1; tbl_wr_addr = 7'(i); tbl_wr_data = 4'((i * 7 + (i >> 3)) % 16);
            idle(1);
        end
        tbl_wr_en = 0;
        // R1: 0x80 returns key word 0
        pkt = '{8'h80};
        send(0, 0);
        @(negedge clk);
        check(out_hash == key_words[0], "R1", "single 0x80", out_hash, key_words[0]);
        idle(1);
        // R2: 0x01 returns key bits 7..38
        pkt = '{8'h01};
        send(0, 0);
        @(negedge clk);
        check(out_hash == ((key_words[0] << 7) | (key_words[1] >> 25)), "R2", "single 0x01",
              out_hash, (key_words[0] << 7) | (key_words[1] >> 25));
        idle(1);
        // R3: all-zero 36-byte input
        pkt.delete();
        for (int i = 0; i < 36; i++) pkt.push_back(8'h00);
        send(0, 0);
        @(negedge clk);
        check(out_hash == 0, "R3", "zero input", out_hash, 0);
        idle(1);
        // R2: all-ones, maximum length
        pkt.delete();
        for (int i = 0; i < 36; i++) pkt.push_back(8'hff);
        send(0, 0); idle(2);
        // R2: address and port pattern, then R3 with gaps and stray flags
        pkt = '{8'h42, 8'h09, 8'h95, 8'hbb, 8'ha1, 8'h8e, 8'h64, 8'h50, 8'h0a, 8'hea, 8'h06, 8'he6};
        send(0, 0); idle(2);
        cur_req = "R3";
        send(0, 2); idle(2);
        // R10: flags without valid inside a packet must not restart or finish it
        cur_req = "R10";
        send(0, 1); idle(2);
        // R3: back-to-back inputs
        cur_req = "R3";
        for (int k = 0; k < 4; k++) begin
            pkt.delete();
            for (int i = 0; i <= k * 3; i++) pkt.push_back(8'(i * 37 + k * 11 + 5));
            send(0, 0);
        end
        idle(2);
        // R7: unparsed packet
        pkt = '{8'h12, 8'h34, 8'h56};
        send(1, 0);
        @(negedge clk);
        check(out_hash == 0 && out_tag == 0 && out_queue == 0, "R7", "unparsed zero", out_hash, 0);
        idle(1);
        // R8: key write during an input does not affect it
        cur_req = "R8";
        in_valid = 1; in_first = 1; in_last = 0; in_data = 8'h80;
        idle(1);
        in_first = 0; in_data = 8'h00;
        key_wr_en = 1; key_wr_addr = 0; key_wr_data = 32'hdeadbeef;
        idle(1);
        key_wr_en = 0; in_last = 1; in_data = 8'h00;
        idle(1);
        in_valid = 0; in_last = 0;
        @(negedge clk);
        check(out_hash == key_words[0], "R8", "old key kept", out_hash, key_words[0]);
        idle(1);
        pkt = '{8'h80};
        send(0, 0);
        @(negedge clk);
        check(out_hash == 32'hdeadbeef, "R8", "new key used next", out_hash, 32'hdeadbeef);
        // R5: table rewrite seen by next lookup
        idle(1);
        tbl_wr_en = 1; tbl_wr_addr = 7'h6f; tbl_wr_data = 4'h9;
        idle(1);
        tbl_wr_en = 0;
        cur_req = "R5";
        send(0, 0);
        @(negedge clk);
        check(out_queue == 4'h9, "R5", "table lookup at hash[6:0]=6f", 32'(out_queue), 32'h9);
        idle(3);
        finish_run();
    end
endmodule